// File: doc/BRIEF.md
# DMA Word Address Counter with Upper Extension

This block holds the memory address that a disk controller's DMA engine uses for each word it moves. The address is a byte address whose lowest bit is always zero. Software sees the low sixteen bits as a register of their own. The two bits above them are read and written through the control/status register. A strobe from the data path moves the address on by one word, which is two bytes. A carry out of the low register ripples into those upper bits.

A build parameter selects a wider mode. In that mode the upper field grows to six bits, so the address is 22 bits wide. An extension register loads all six upper bits. The two control/status bits still alias the lowest two of them.

When the address steps past its highest value it wraps to zero. A sticky flag records that this happened, and it stays set until reset.

Top module: `dma_word_addr_ctr`

## Requirements
- R1: After reset, addr, lo_rdata, csr_rd, ext_rdata and wrapped are all zero.
- R2: A write to the low register stores lo_wdata bits 15:1. lo_rdata bit 0 always reads zero, whatever value was written to it.
- R3: A step with no write in the same cycle raises addr by exactly 2 (modulo the address width) on the next clock edge.
- R4: A step that takes lo_rdata from 16'hFFFE to zero increments the upper field, so addr bit 16 and above go up by one.
- R5: csr_wr loads csr_bits into addr bits 17:16. The value appears on csr_rd on the next clock edge.
- R6: Any write in a cycle (lo_wr, csr_wr, or ext_wr in wide mode) cancels a step in that same cycle.
- R7: A step taken from the top address (all address bits one except bit 0) gives addr zero and sets wrapped. wrapped then stays set until reset.
- R8: With WIDE=1, addr is 22 bits wide. ext_wr loads ext_wdata into addr bits 21:16, and carries reach all six upper bits.
- R9: With WIDE=0, ext_wr has no effect: it neither changes the address nor cancels a step. ext_rdata reads as {4'b0, csr_rd}.
- R10: addr always equals {upper field, lo_rdata}. lo_rdata always equals addr[15:0].
- R11: When csr_wr and ext_wr occur in the same cycle in wide mode, csr_bits set addr bits 17:16 and ext_wdata sets bits 21:18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low initialization |
| lo_wr | input | 1 | Write strobe for the low register |
| lo_wdata | input | 16 | Data for the low register |
| csr_wr | input | 1 | Write strobe for the two control/status address bits |
| csr_bits | input | 2 | New value for address bits 17:16 |
| ext_wr | input | 1 | Write strobe for the extension register (acts only in wide mode) |
| ext_wdata | input | 6 | New value for address bits 21:16 |
| step | input | 1 | One word transferred; advance the address |
| lo_rdata | output | 16 | Low register read value, bit 0 always zero |
| csr_rd | output | 2 | Address bits 17:16 as seen in the control/status register |
| ext_rdata | output | 6 | Upper field read value, zero-extended in narrow mode |
| addr | output | 18 or 22 | Full byte address for the bus master |
| wrapped | output | 1 | Sticky flag: the address has wrapped past its top |

## Verification
The bench builds two instances side by side and drives both with the same stimulus: one with WIDE=0 and one with WIDE=1. The narrow instance exercises the control/status aliasing, extension writes that must be ignored, and the 18-bit wrap. The wide instance exercises the six-bit carry chain, write merging between the extension and control/status bits, and the 22-bit wrap. Random writes to the low register favour values near 16'hFFFE, so that carries into the upper field happen often in a short run.

// File: rtl/dma_word_addr_ctr.sv
module dma_word_addr_ctr #(
  parameter bit WIDE  = 1'b0,
  parameter int LO_W  = 16,
  parameter int CSR_W = 2,
  parameter int EXT_W = 6,
  localparam int UW   = WIDE ? EXT_W : CSR_W,
  localparam int AW   = LO_W + UW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_wr,
  input  logic [LO_W-1:0]  lo_wdata,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_bits,
  input  logic             ext_wr,
  input  logic [EXT_W-1:0] ext_wdata,
  input  logic             step,
  output logic [LO_W-1:0]  lo_rdata,
  output logic [CSR_W-1:0] csr_rd,
  output logic [EXT_W-1:0] ext_rdata,
  output logic [AW-1:0]    addr,
  output logic             wrapped
);

  logic [LO_W-1:1] lo_q;
  logic [UW-1:0]   up_q, up_n;
  logic            wrap_q;

  wire          ext_take = WIDE && ext_wr;
  wire          wr_any   = lo_wr || csr_wr || ext_take;
  wire [AW-1:0] cnt_inc  = {1'b0, up_q, lo_q} + AW'(1);

  always_comb begin
    up_n = up_q;
    if (ext_take) up_n = ext_wdata[UW-1:0];
    if (csr_wr)   up_n[CSR_W-1:0] = csr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      up_q   <= '0;
      wrap_q <= 1'b0;
    end else if (wr_any) begin
      if (lo_wr) lo_q <= lo_wdata[LO_W-1:1];
      up_q <= up_n;
    end else if (step) begin
      {up_q, lo_q} <= cnt_inc[AW-2:0];
      if (cnt_inc[AW-1]) wrap_q <= 1'b1;
    end
  end

  assign lo_rdata = {lo_q, 1'b0};
  assign csr_rd   = up_q[CSR_W-1:0];
  assign addr     = {up_q, lo_q, 1'b0};
  assign wrapped  = wrap_q;

  generate
    if (UW == EXT_W) begin : g_ext_full
      assign ext_rdata = up_q;
    end else begin : g_ext_pad
      assign ext_rdata = {{(EXT_W-UW){1'b0}}, up_q};
    end
  endgenerate

  assert_step_plus_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_any) |=> addr == $past(addr) + AW'(2));

  assert_carry_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_any && lo_rdata == {{(LO_W-1){1'b1}}, 1'b0})
      |=> (lo_rdata == '0 && addr[AW-1:LO_W] == $past(addr[AW-1:LO_W]) + UW'(1)));

  assert_csr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |=> csr_rd == $past(csr_bits));

  assert_lo_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> lo_rdata == {$past(lo_wdata[LO_W-1:1]), 1'b0});

  assert_wrap_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);

endmodule

// File: tb/dma_word_addr_ctr_bench.sv
`timescale 1ns/1ps
module dma_word_addr_ctr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        lo_wr = 0, csr_wr = 0, ext_wr = 0, step = 0;
  logic [15:0] lo_wdata = '0;
  logic [1:0]  csr_bits = '0;
  logic [5:0]  ext_wdata = '0;

  logic [15:0] n_lo, w_lo;
  logic [1:0]  n_csr, w_csr;
  logic [5:0]  n_ext, w_ext;
  logic [17:0] n_addr;
  logic [21:0] w_addr;
  logic        n_wrap, w_wrap;

  dma_word_addr_ctr #(.WIDE(1'b0)) u_dma_word_addr_ctr (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
    .csr_wr(csr_wr), .csr_bits(csr_bits), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
    .step(step), .lo_rdata(n_lo), .csr_rd(n_csr), .ext_rdata(n_ext),
    .addr(n_addr), .wrapped(n_wrap));

  dma_word_addr_ctr #(.WIDE(1'b1)) u_dma_word_addr_ctr_wide (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
    .csr_wr(csr_wr), .csr_bits(csr_bits), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
    .step(step), .lo_rdata(w_lo), .csr_rd(w_csr), .ext_rdata(w_ext),
    .addr(w_addr), .wrapped(w_wrap));

  int errors = 0, checks = 0;
  logic [21:0] m_n = '0, m_w = '0;
  bit mw_n = 0, mw_w = 0;

  function automatic logic [21:0] nxt(input logic [21:0] a, input bit wide, output bit wr_out);
    logic [21:0] mask, r;
    bit wr;
    mask = wide ? 22'h3FFFFF : 22'h03FFFF;
    wr = lo_wr || csr_wr || (wide && ext_wr);
    r = a;
    wr_out = 0;
    if (wr) begin
      if (lo_wr) r[15:0] = {lo_wdata[15:1], 1'b0};
      if (wide && ext_wr) r[21:16] = ext_wdata;
      if (csr_wr) r[17:16] = csr_bits;
    end else if (step) begin
      wr_out = (a == (mask & ~22'h1));
      r = (a + 22'd2) & mask;
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "narrow addr", 32'(n_addr), 32'(m_n[17:0]));
    chk(req, "narrow lo", 32'(n_lo), 32'(m_n[15:0]));
    chk(req, "narrow csr", 32'(n_csr), 32'(m_n[17:16]));
    chk(req, "narrow ext", 32'(n_ext), {30'b0, m_n[17:16]});
    chk(req, "narrow wrap", 32'(n_wrap), 32'(mw_n));
    chk(req, "wide addr", 32'(w_addr), 32'(m_w));
    chk(req, "wide lo", 32'(w_lo), 32'(m_w[15:0]));
    chk(req, "wide csr", 32'(w_csr), 32'(m_w[17:16]));
    chk(req, "wide ext", 32'(w_ext), 32'(m_w[21:16]));
    chk(req, "wide wrap", 32'(w_wrap), 32'(mw_w));
  endtask

  task automatic cyc(input string req);
    bit fn, fw;
    logic [21:0] a_n, a_w;
    @(posedge clk);
    #1;
    a_n = nxt(m_n, 1'b0, fn);
    a_w = nxt(m_w, 1'b1, fw);
    m_n = a_n; m_w = a_w;
    if (fn) mw_n = 1;
    if (fw) mw_w = 1;
    check_all(req);
    lo_wr = 0; csr_wr = 0; ext_wr = 0; step = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check_all("R1");

    lo_wr = 1; lo_wdata = 16'h1235; cyc("R2");
    step = 1; cyc("R3");
    step = 1; cyc("R3");
    lo_wr = 1; lo_wdata = 16'hFFFE; cyc("R2");
    step = 1; cyc("R4");
    csr_wr = 1; csr_bits = 2'b10; cyc("R5");
    lo_wr = 1; lo_wdata = 16'h0040; step = 1; cyc("R6");
    csr_wr = 1; csr_bits = 2'b01; step = 1; cyc("R6");
    ext_wr = 1; ext_wdata = 6'h2A; step = 1; cyc("R9");
    ext_wr = 1; ext_wdata = 6'h15; csr_wr = 1; csr_bits = 2'b11; cyc("R11");
    lo_wr = 1; lo_wdata = 16'hFFFF; cyc("R8");
    step = 1; cyc("R8");
    ext_wr = 1; ext_wdata = 6'h3F; csr_wr = 1; csr_bits = 2'b11; lo_wr = 1; lo_wdata = 16'hFFFE; cyc("R7");
    step = 1; cyc("R7");
    step = 1; cyc("R7");
    csr_wr = 1; csr_bits = 2'b00; cyc("R7");

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 100);
      step = ($urandom % 100) < 85;
      lo_wr = r < 4;
      csr_wr = (r >= 4) && (r < 7);
      ext_wr = (r >= 7) && (r < 10);
      lo_wdata = ($urandom % 2) ? (16'hFFC0 | 16'($urandom % 64)) : 16'($urandom);
      csr_bits = 2'($urandom);
      ext_wdata = ($urandom % 2) ? 6'h3F : 6'($urandom);
      cyc("R10");
    end
    finish_run();
  end
endmodule